// File: doc/BRIEF.md
# Core Deep-Sleep Power Sequencer

This controller takes one processor core from normal execution into a power-gated deep sleep and brings it back. Software or firmware raises a sleep request. The sequencer then works through five handshakes, one after the other: it drains the pipeline, copies the architectural registers into an on-die retention SRAM, writes the L1 caches back to the next cache level, stops the core clock and switches the supply regulator off. Each handshake is a level request paired with a level acknowledge. A step starts only when the previous step has been acknowledged.

Three wake sources end the sleep: an interrupt, a scheduler event and a hit on a monitored address. Exit releases the same requests in the reverse order. The supply comes back first, then the clock, then the cache state. The registers are reloaded after that, and the pipeline is released last, so execution continues after the instruction that slept. A retention mode skips the L1 write-back so that the caches keep their contents in retention storage.

A wake that arrives before the clock-gate step unwinds only the steps already taken. A stalled handshake times out against a programmable limit. Two counters report how many cycles the most recent entry and the most recent exit took.

Top module: `core_sleep_seq`

## Requirements
- R1: After reset, `status` is 0, `ph_req` is all zero, and `seq_err`, `l1_retained`, `entry_lat` and `exit_lat` are 0. The `status` codes are 0 active, 1 entering, 2 asleep, 3 exiting and 4 unwinding an aborted entry.
- R2: Entry is accepted only on a clock edge where `sleep_req` is high and `status` is 0. At that edge `status` becomes 1 and `ph_req` becomes 5'b00001.
- R3: The `ph_req` bits are, from bit 0 upward: pipeline flush, register save, L1 write-back, clock gate and power off. During entry, bit k+1 is raised only on the edge after the acknowledge of the previous requested step is seen high.
- R4: When `retain_l1` is high at acceptance, `l1_retained` is 1 for the whole transition and `ph_req[2]` never rises. In that mode the step after register save is clock gate.
- R5: Once the power-off acknowledge is seen, `status` becomes 2. It stays 2, and every requested bit stays high, until a wake event arrives.
- R6: While `status` is 2, a pulse on any one of `wake_irq`, `wake_sched` or `wake_mon` starts exit (`status` 3). Exit clears the requests from bit 4 down to bit 0, each one after the acknowledge of the bit above has been seen low. `status` returns to 0 after `ph_ack[0]` is seen low.
- R7: A wake event during entry, while the clock-gate request is still low, sets `status` to 4. It clears only the requests already raised, from the highest down, raises no new request, and returns to 0.
- R8: A wake event that arrives after the clock-gate request has risen is held. Entry completes to `status` 2, and exit then starts on the next edge.
- R9: If a step's acknowledge has not changed `tmo_limit`+1 edges after the step starts, `seq_err` becomes 1, all of `ph_req` drops and `status` returns to 0. `seq_err` clears when the next entry is accepted.
- R10: `entry_lat` is 1 plus one for each edge spent with `status` 1. `exit_lat` is 1 plus one for each edge spent with `status` 3 or 4. Each counter loads at the start of its transition and holds its value until the next one starts. With acknowledges that follow the requests after one cycle, both counters read 11, or 9 in retention mode.
- R11: A `sleep_req` seen while `status` is not 0 has no effect. A wake event while `status` is 0 has no effect, either at once or later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep request from software or firmware |
| retain_l1 | input | 1 | Keep L1 in retention instead of writing it back |
| wake_irq | input | 1 | Interrupt wake event |
| wake_sched | input | 1 | Scheduler wake event |
| wake_mon | input | 1 | Monitored-address write wake event |
| tmo_limit | input | TMO_W | Per-step handshake timeout limit |
| ph_ack | input | 5 | Step acknowledges, same bit order as ph_req |
| ph_req | output | 5 | Step requests: flush, save, L1 write-back, clock gate, power off |
| l1_retained | output | 1 | Current transition uses L1 retention |
| status | output | 3 | Sequencer state code |
| seq_err | output | 1 | Last transition ended by a handshake timeout |
| entry_lat | output | LAT_W | Cycle count of the latest entry |
| exit_lat | output | LAT_W | Cycle count of the latest exit or unwind |

## Verification
The bench builds the block with TMO_W = 8 and LAT_W = 12. With an 8-bit limit the bench can set a timeout of a few cycles, so a stalled step times out within tens of cycles; a larger limit lets a stalled step hold the sequencer long enough for a wake event to be injected mid-entry. Twelve counter bits hold every measured latency (9 and 11 with one-cycle responders, 4 for an early unwind) well clear of saturation, so the exact counts are compared and the saturating top of the counter is not reached. The acknowledge responders can hold any chosen step low, and that is what brings the timeout and abort paths within reach.

// File: rtl/sleep_seq_pkg.sv
`timescale 1ns/1ps
package sleep_seq_pkg;
  // Step order is behaviour: entry raises upward, exit releases downward.
  localparam int N_PH     = 5;
  localparam int PH_FLUSH = 0;
  localparam int PH_SAVE  = 1;
  localparam int PH_L1    = 2;
  localparam int PH_CLK   = 3;
  localparam int PH_PWR   = 4;
  localparam int IDX_W    = $clog2(N_PH);
  localparam int N_WAKE   = 3;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_ENTER  = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_EXIT   = 3'd3,
    ST_UNWIND = 3'd4
  } seq_state_e;
endpackage

// File: rtl/seq_phase_timer.sv
`timescale 1ns/1ps
module seq_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (cnt_q != limit) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == limit);
endmodule

// File: rtl/seq_lat_ctr.sv
`timescale 1ns/1ps
module seq_lat_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         run,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] SAT = '1;
  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) val_q <= '0;
    else if (start) val_q <= W'(1);
    else if (run && val_q != SAT) val_q <= val_q + 1'b1;
  end

  assign value = val_q;
endmodule

// File: rtl/seq_wake_merge.sv
`timescale 1ns/1ps
module seq_wake_merge #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  input  logic             arm,
  input  logic             clr,
  output logic             wake_now,
  output logic             wake_pend
);
  logic pend_q;

  assign wake_now = |src;

  always_ff @(posedge clk) begin
    if (rst || clr) pend_q <= 1'b0;
    else if (arm && wake_now) pend_q <= 1'b1;
  end

  assign wake_pend = pend_q;
endmodule

// File: rtl/core_sleep_seq.sv
`timescale 1ns/1ps
module core_sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int TMO_W = 8,
  parameter int LAT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             retain_l1,
  input  logic             wake_irq,
  input  logic             wake_sched,
  input  logic             wake_mon,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [N_PH-1:0]  ph_ack,
  output logic [N_PH-1:0]  ph_req,
  output logic             l1_retained,
  output logic [2:0]       status,
  output logic             seq_err,
  output logic [LAT_W-1:0] entry_lat,
  output logic [LAT_W-1:0] exit_lat
);
  localparam logic [IDX_W-1:0] I_L1  = IDX_W'(PH_L1);
  localparam logic [IDX_W-1:0] I_CLK = IDX_W'(PH_CLK);
  localparam logic [IDX_W-1:0] I_PWR = IDX_W'(PH_PWR);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [N_PH-1:0]  req_q, req_d;
  logic             ret_q, ret_d;
  logic             err_q, err_d;
  logic             ent_start, ext_start;
  logic             phase_go, tmo_hit;
  logic             wake_now, wake_pend;
  logic             ack_cur;

  // Next step upward, skipping the L1 write-back in retention mode.
  function automatic logic [IDX_W-1:0] step_up(input logic [IDX_W-1:0] i, input logic skip);
    logic [IDX_W-1:0] n;
    n = i + 1'b1;
    if (skip && n == I_L1) n = n + 1'b1;
    return n;
  endfunction

  function automatic logic [IDX_W-1:0] step_dn(input logic [IDX_W-1:0] i, input logic skip);
    logic [IDX_W-1:0] n;
    n = i - 1'b1;
    if (skip && n == I_L1) n = n - 1'b1;
    return n;
  endfunction

  assign ack_cur = ph_ack[idx_q];

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    req_d     = req_q;
    ret_d     = ret_q;
    err_d     = err_q;
    ent_start = 1'b0;
    ext_start = 1'b0;
    case (state_q)
      ST_ACTIVE: begin
        if (sleep_req) begin
          state_d          = ST_ENTER;
          idx_d            = '0;
          req_d            = '0;
          req_d[PH_FLUSH]  = 1'b1;
          ret_d            = retain_l1;
          err_d            = 1'b0;
          ent_start        = 1'b1;
        end
      end
      ST_ENTER: begin
        if (wake_now && idx_q < I_CLK) begin
          state_d       = ST_UNWIND;
          req_d[idx_q]  = 1'b0;
          ext_start     = 1'b1;
        end else if (ack_cur) begin
          if (idx_q == I_PWR) begin
            state_d = ST_SLEEP;
          end else begin
            idx_d        = step_up(idx_q, ret_q);
            req_d[idx_d] = 1'b1;
          end
        end else if (tmo_hit) begin
          state_d = ST_ACTIVE;
          idx_d   = '0;
          req_d   = '0;
          ret_d   = 1'b0;
          err_d   = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wake_now || wake_pend) begin
          state_d       = ST_EXIT;
          idx_d         = I_PWR;
          req_d[PH_PWR] = 1'b0;
          ext_start     = 1'b1;
        end
      end
      default: begin
        if (!ack_cur) begin
          if (idx_q == '0) begin
            state_d = ST_ACTIVE;
            ret_d   = 1'b0;
          end else begin
            idx_d        = step_dn(idx_q, ret_q);
            req_d[idx_d] = 1'b0;
          end
        end else if (tmo_hit) begin
          state_d = ST_ACTIVE;
          idx_d   = '0;
          req_d   = '0;
          ret_d   = 1'b0;
          err_d   = 1'b1;
        end
      end
    endcase
  end

  assign phase_go = (state_d != state_q) || (idx_d != idx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ACTIVE;
      idx_q   <= '0;
      req_q   <= '0;
      ret_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      req_q   <= req_d;
      ret_q   <= ret_d;
      err_q   <= err_d;
    end
  end

  seq_phase_timer #(.W(TMO_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (phase_go),
    .limit   (tmo_limit),
    .hit     (tmo_hit)
  );

  seq_wake_merge #(.N_SRC(N_WAKE)) u_wake (
    .clk       (clk),
    .rst       (rst),
    .src       ({wake_mon, wake_sched, wake_irq}),
    .arm       ((state_q == ST_ENTER) && (idx_q >= I_CLK)),
    .clr       ((state_q == ST_ACTIVE) || ext_start),
    .wake_now  (wake_now),
    .wake_pend (wake_pend)
  );

  seq_lat_ctr #(.W(LAT_W)) u_ent_lat (
    .clk   (clk),
    .rst   (rst),
    .start (ent_start),
    .run   (state_q == ST_ENTER),
    .value (entry_lat)
  );

  seq_lat_ctr #(.W(LAT_W)) u_ext_lat (
    .clk   (clk),
    .rst   (rst),
    .start (ext_start),
    .run   ((state_q == ST_EXIT) || (state_q == ST_UNWIND)),
    .value (exit_lat)
  );

  assign ph_req      = req_q;
  assign l1_retained = ret_q;
  assign status      = state_q;
  assign seq_err     = err_q;
endmodule

// File: rtl/core_sleep_seq_chk.sv
`timescale 1ns/1ps
module core_sleep_seq_chk #(
  parameter int TMO_W = 8,
  parameter int LAT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_req,
  input logic [4:0]       ph_ack,
  input logic [4:0]       ph_req,
  input logic             l1_retained,
  input logic [2:0]       status,
  input logic             seq_err,
  input logic [LAT_W-1:0] entry_lat,
  input logic [TMO_W-1:0] tmo_limit
);
  a_r2_start_only_active: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_req[0]) |-> ($past(sleep_req) && $past(status) == 3'd0));

  a_r3_save_after_flush: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_req[1]) |-> $past(ph_ack[0]));
  a_r3_l1_after_save: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_req[2]) |-> $past(ph_ack[1]));
  a_r3_clk_after_prev: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_req[3]) |-> ($past(ph_ack[2]) || ($past(ph_ack[1]) && l1_retained)));
  a_r3_pwr_after_clk: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_req[4]) |-> $past(ph_ack[3]));

  a_r4_no_l1_request: assert property (@(posedge clk) disable iff (rst)
    l1_retained |-> !ph_req[2]);

  a_r5_asleep_all_held: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd2) |-> (ph_req[4] && ph_req[3] && ph_req[1] && ph_req[0]));

  a_r6_release_clk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ph_req[3]) && !seq_err) |-> $past(!ph_ack[4]));
  a_r6_release_save: assert property (@(posedge clk) disable iff (rst)
    ($fell(ph_req[1]) && !seq_err) |-> ($past(!ph_ack[2]) && $past(!ph_ack[3])));
  a_r6_release_flush: assert property (@(posedge clk) disable iff (rst)
    ($fell(ph_req[0]) && !seq_err) |-> $past(!ph_ack[1]));

  a_r7_unwind_no_gate: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd4) |-> (!ph_req[3] && !ph_req[4]));

  a_r9_timeout_returns: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_err) |-> (status == 3'd0 && ph_req == 5'd0 && $past(status) != 3'd0));

  a_r10_entry_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(status) == 3'd2 && status == 3'd2) |-> $stable(entry_lat));
endmodule

bind core_sleep_seq core_sleep_seq_chk #(.TMO_W(TMO_W), .LAT_W(LAT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sleep_req   (sleep_req),
  .ph_ack      (ph_ack),
  .ph_req      (ph_req),
  .l1_retained (l1_retained),
  .status      (status),
  .seq_err     (seq_err),
  .entry_lat   (entry_lat),
  .tmo_limit   (tmo_limit)
);

// File: tb/core_sleep_seq_bench.sv
`timescale 1ns/1ps
module core_sleep_seq_bench;
  localparam int TMO_W = 8;
  localparam int LAT_W = 12;

  typedef struct packed {
    logic       ret;
    logic [1:0] src;
    logic [4:0] pat;
    int         ent;
    int         ext;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 2'd0, 5'b11111, 11, 11},
    '{1'b0, 2'd1, 5'b11111, 11, 11},
    '{1'b1, 2'd2, 5'b11011,  9,  9},
    '{1'b1, 2'd0, 5'b11011,  9,  9}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sleep_req = 1'b0;
  logic             retain_l1 = 1'b0;
  logic             wake_irq = 1'b0;
  logic             wake_sched = 1'b0;
  logic             wake_mon = 1'b0;
  logic [TMO_W-1:0] tmo_limit = 8'd8;
  logic [4:0]       ph_ack;
  logic [4:0]       ph_req;
  logic [4:0]       stall = 5'd0;
  logic             l1_retained;
  logic [2:0]       status;
  logic             seq_err;
  logic [LAT_W-1:0] entry_lat;
  logic [LAT_W-1:0] exit_lat;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  // Responders: each acknowledge follows its request one cycle later unless stalled.
  always_ff @(posedge clk) begin
    if (rst) ph_ack <= '0;
    else ph_ack <= ph_req & ~stall;
  end

  core_sleep_seq #(.TMO_W(TMO_W), .LAT_W(LAT_W)) u_core_sleep_seq (
    .clk         (clk),
    .rst         (rst),
    .sleep_req   (sleep_req),
    .retain_l1   (retain_l1),
    .wake_irq    (wake_irq),
    .wake_sched  (wake_sched),
    .wake_mon    (wake_mon),
    .tmo_limit   (tmo_limit),
    .ph_ack      (ph_ack),
    .ph_req      (ph_req),
    .l1_retained (l1_retained),
    .status      (status),
    .seq_err     (seq_err),
    .entry_lat   (entry_lat),
    .exit_lat    (exit_lat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sleep(input logic ret);
    @(negedge clk);
    sleep_req = 1'b1;
    retain_l1 = ret;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic pulse_wake(input int src);
    @(negedge clk);
    wake_irq   = (src == 0);
    wake_sched = (src == 1);
    wake_mon   = (src == 2);
    @(negedge clk);
    wake_irq   = 1'b0;
    wake_sched = 1'b0;
    wake_mon   = 1'b0;
  endtask

  task automatic wait_status(input logic [2:0] s, input string tag);
    int k = 0;
    while (status != s && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(tag, int'(status), int'(s));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 status", int'(status), 0);
    chk("R1 requests", int'(ph_req), 0);
    chk("R1 err", int'(seq_err), 0);
    chk("R1 entry_lat", int'(entry_lat), 0);
    chk("R1 exit_lat", int'(exit_lat), 0);
    chk("R1 retained", int'(l1_retained), 0);

    // Table of full sleep/wake round trips
    for (int v = 0; v < 4; v++) begin
      pulse_sleep(VECS[v].ret);
      wait_status(3'd2, "R5 reach sleep");
      chk("R5 request pattern", int'(ph_req), int'(VECS[v].pat));
      chk("R4 retention flag", int'(l1_retained), int'(VECS[v].ret));
      chk("R10 entry latency", int'(entry_lat), VECS[v].ent);
      cyc(3);
      chk("R10 entry held", int'(entry_lat), VECS[v].ent);
      chk("R5 stays asleep", int'(status), 2);
      pulse_wake(int'(VECS[v].src));
      wait_status(3'd0, "R6 back active");
      chk("R6 all released", int'(ph_req), 0);
      chk("R10 exit latency", int'(exit_lat), VECS[v].ext);
      chk("R4 flag cleared", int'(l1_retained), 0);
    end

    // R2 acceptance
    cyc(3);
    chk("R2 idle without request", int'(status), 0);
    pulse_sleep(1'b0);
    chk("R2 entering", int'(status), 1);
    chk("R2 flush first", int'(ph_req), 1);
    wait_status(3'd2, "R5 reach sleep");
    pulse_wake(0);
    wait_status(3'd0, "R6 back active");

    // R7 abort before clock gate: save step stalled, wake mid-entry
    stall     = 5'b00010;
    tmo_limit = 8'd40;
    pulse_sleep(1'b0);
    cyc(4);
    chk("R7 waiting on save", int'(status), 1);
    chk("R7 flush and save raised", int'(ph_req), 3);
    pulse_wake(1);
    chk("R7 unwinding", int'(status), 4);
    chk("R7 save released first", int'(ph_req), 1);
    wait_status(3'd0, "R7 back active");
    chk("R7 requests clear", int'(ph_req), 0);
    chk("R10 unwind latency", int'(exit_lat), 4);
    chk("R7 no error", int'(seq_err), 0);
    stall     = 5'd0;
    tmo_limit = 8'd8;
    cyc(2);

    // R8 late wake after clock gate request
    begin
      int k = 0;
      int seen = 0;
      pulse_sleep(1'b0);
      while (!ph_req[3] && k < 50) begin
        @(negedge clk);
        k++;
      end
      pulse_wake(2);
      k = 0;
      while (status != 3'd0 && k < 100) begin
        if (status == 3'd2) seen = 1;
        @(negedge clk);
        k++;
      end
      chk("R8 sleep reached", seen, 1);
      chk("R8 back active", int'(status), 0);
      chk("R8 full entry", int'(entry_lat), 11);
      chk("R8 full exit", int'(exit_lat), 11);
    end

    // R9 timeout on L1 write-back step
    stall     = 5'b00100;
    tmo_limit = 8'd5;
    pulse_sleep(1'b0);
    wait_status(3'd0, "R9 returns active");
    chk("R9 error flag", int'(seq_err), 1);
    chk("R9 requests dropped", int'(ph_req), 0);
    stall     = 5'd0;
    tmo_limit = 8'd8;
    cyc(2);
    pulse_sleep(1'b0);
    chk("R9 error cleared", int'(seq_err), 0);
    wait_status(3'd2, "R5 reach sleep");
    pulse_wake(0);
    wait_status(3'd0, "R6 back active");

    // R11 second request ignored while busy
    pulse_sleep(1'b0);
    @(negedge clk);
    sleep_req = 1'b1;
    cyc(3);
    sleep_req = 1'b0;
    wait_status(3'd2, "R11 reach sleep");
    chk("R11 entry unchanged", int'(entry_lat), 11);
    @(negedge clk);
    sleep_req = 1'b1;
    cyc(3);
    chk("R11 asleep kept", int'(status), 2);
    sleep_req = 1'b0;
    pulse_wake(0);
    wait_status(3'd0, "R11 back active");
    chk("R11 exit unchanged", int'(exit_lat), 11);
    cyc(4);
    chk("R11 no re-entry", int'(status), 0);

    // R11 wake while active has no effect
    pulse_wake(1);
    cyc(3);
    chk("R11 wake ignored status", int'(status), 0);
    chk("R11 wake ignored requests", int'(ph_req), 0);
    pulse_sleep(1'b0);
    wait_status(3'd2, "R11 reach sleep");
    cyc(5);
    chk("R11 no stale wake", int'(status), 2);
    pulse_wake(2);
    wait_status(3'd0, "R6 back active");

    // R1 reset while asleep
    pulse_sleep(1'b1);
    wait_status(3'd2, "R5 reach sleep");
    @(negedge clk);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset requests", int'(ph_req), 0);
    chk("R1 reset retained", int'(l1_retained), 0);
    chk("R1 reset latency", int'(entry_lat), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule